// File: doc/BRIEF.md
# Wait-Inducing Row Detector

This block watches the requests and row activates that a memory controller handles. It picks out the rows that made a later request wait. Every activate keeps its bank busy for a fixed row-cycle window. If a request for another row of that bank arrives inside the window, that request has to stall until the window closes. The row that was open when the request arrived is then marked as wait-inducing. The detector reports that row to the near-segment cache fill logic as an insertion hint. Rows that never cause such a stall are never proposed for caching, however often they are used.

Each bank has its own tracker, so windows in different banks run side by side. The block only observes and never stalls its sources, so no input has a ready signal. The hint output is a single-cycle pulse with no handshake, and a consumer that is not able to take it lets it pass. The subarray reported with a hint is the upper `SA_W` bits of the row address.

Top module: `wir_detector`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `hint_valid` is 0 and every bank is idle.
- R2: An activate presented in cycle c makes its bank busy in cycles c+1 through c+TRC, which is exactly TRC cycles. A conflicting request in cycle c+TRC still counts; one in cycle c+TRC+1 does not.
- R3: A valid request that targets a busy bank with a row different from that bank's open row is a conflict. A conflict raises `hint_valid` for exactly one cycle, in the cycle after the request, with `hint_bank` set to the request's bank and `hint_row` set to the bank's open row.
- R4: `hint_subarray` equals bits [ROW_W-1 : ROW_W-SA_W] of `hint_row`.
- R5: A request for the bank's open row never raises a hint.
- R6: A request to a bank whose window is not running never raises a hint, even while other banks are busy.
- R7: At most one hint is raised per activate, however many conflicts arrive in its window.
- R8: A new activate to a bank restarts its window and makes the bank eligible for one more hint.
- R9: A request with `req_valid` low has no effect.
- R10: Banks are tracked independently. Overlapping windows in two banks each produce their own hint, carrying their own open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| act_valid | input | 1 | An activate was issued this cycle |
| act_bank | input | BANK_W | Bank being activated |
| act_row | input | ROW_W | Row being activated |
| hint_valid | output | 1 | One-cycle insertion hint pulse |
| hint_bank | output | BANK_W | Bank of the wait-inducing row |
| hint_subarray | output | SA_W | Subarray of the wait-inducing row |
| hint_row | output | ROW_W | The wait-inducing row |

## Verification
A hint is due one clock edge after the conflicting request: the request is sampled on that edge and the hint register updates on the same edge. The bench drives its inputs on the falling edge and samples outputs 1 ns after each rising edge. Before each rising edge it predicts, from its own per-bank record of activate cycles, open rows and hint flags, what the outputs will show just after that edge. It then compares `hint_valid` on every cycle and the three fields on every expected hint. The sweep places a request at every offset from 1 to TRC+2 cycles after an activate. That covers both ends of the window.

// File: rtl/wir_pkg.sv
package wir_pkg;
  // Width of a down-counter that must hold values 0..limit.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/wir_bank_tracker.sv
module wir_bank_tracker #(
  parameter int unsigned ROW_W = 12,
  parameter int unsigned TRC   = 28,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic [ROW_W-1:0] act_row_i,
  input  logic             req_hit_i,
  input  logic [ROW_W-1:0] req_row_i,
  output logic             fire_o,
  output logic [ROW_W-1:0] row_o
);
  localparam logic [CNT_W-1:0] WINDOW = CNT_W'(TRC);

  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] open_row_q;
  logic             flagged_q;
  logic             busy;

  assign busy   = (cnt_q != '0);
  assign fire_o = req_hit_i && busy && (req_row_i != open_row_q) && !flagged_q;
  assign row_o  = open_row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      open_row_q <= '0;
      flagged_q  <= 1'b0;
    end else begin
      if (act_i)     cnt_q <= WINDOW;
      else if (busy) cnt_q <= cnt_q - 1'b1;
      if (act_i)       open_row_q <= act_row_i;
      if (act_i)       flagged_q  <= 1'b0;
      else if (fire_o) flagged_q  <= 1'b1;
    end
  end

  // R2: the busy window never exceeds the configured length
  assert_window_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WINDOW);
  // R2: an activate reloads the full window
  assert_window_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> (cnt_q == WINDOW));
  // R7: a second hint needs a fresh activate in between
  assert_single_hint_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (!fire_o || $past(act_i)));
endmodule

// File: rtl/wir_hint_select.sv
module wir_hint_select #(
  parameter int unsigned NB     = 8,
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned BANK_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NB-1:0]           fire_i,
  input  logic [NB-1:0][ROW_W-1:0] rows_i,
  output logic                    any_o,
  output logic [BANK_W-1:0]       bank_o,
  output logic [ROW_W-1:0]        row_o
);
  always_comb begin
    any_o  = 1'b0;
    bank_o = '0;
    row_o  = '0;
    for (int i = 0; i < NB; i++) begin
      if (fire_i[i]) begin
        any_o  = 1'b1;
        bank_o = BANK_W'(i);
        row_o  = rows_i[i];
      end
    end
  end

  // R6: one request per cycle, so at most one bank can report a conflict
  assert_one_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_i));
endmodule

// File: rtl/wir_detector.sv
module wir_detector #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned SA_W      = 5,
  parameter int unsigned TRC       = 28,
  localparam int unsigned BANK_W   = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic              act_valid,
  input  logic [BANK_W-1:0] act_bank,
  input  logic [ROW_W-1:0]  act_row,
  output logic              hint_valid,
  output logic [BANK_W-1:0] hint_bank,
  output logic [SA_W-1:0]   hint_subarray,
  output logic [ROW_W-1:0]  hint_row
);
  localparam int unsigned CNT_W = wir_pkg::cnt_width(TRC);

  logic [NUM_BANKS-1:0]            fire;
  logic [NUM_BANKS-1:0][ROW_W-1:0] open_rows;
  logic                            sel_any;
  logic [BANK_W-1:0]               sel_bank;
  logic [ROW_W-1:0]                sel_row;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic act_here;
    logic req_here;
    assign act_here = act_valid && (act_bank == BANK_W'(b));
    assign req_here = req_valid && (req_bank == BANK_W'(b));
    wir_bank_tracker #(.ROW_W(ROW_W), .TRC(TRC), .CNT_W(CNT_W)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_i     (act_here),
      .act_row_i (act_row),
      .req_hit_i (req_here),
      .req_row_i (req_row),
      .fire_o    (fire[b]),
      .row_o     (open_rows[b])
    );
  end

  wir_hint_select #(.NB(NUM_BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (fire),
    .rows_i (open_rows),
    .any_o  (sel_any),
    .bank_o (sel_bank),
    .row_o  (sel_row)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hint_valid <= 1'b0;
      hint_bank  <= '0;
      hint_row   <= '0;
    end else begin
      hint_valid <= sel_any;
      if (sel_any) begin
        hint_bank <= sel_bank;
        hint_row  <= sel_row;
      end
    end
  end

  assign hint_subarray = hint_row[ROW_W-1 -: SA_W];

  // R9: every hint traces back to a valid request one cycle earlier
  assert_hint_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hint_valid |-> $past(req_valid));
  // R3: the hint names the bank the conflicting request targeted
  assert_hint_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hint_valid |-> (hint_bank == $past(req_bank)));
  // R5: the reported row is never the row the request asked for
  assert_hint_diff_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hint_valid |-> (hint_row != $past(req_row)));
  // R1: no hint in the first cycle out of reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> !hint_valid);
endmodule

// File: tb/wir_detector_test.sv
module wir_detector_test;
  localparam int NB = 4;
  localparam int RW = 6;
  localparam int SW = 2;
  localparam int TR = 5;
  localparam int BW = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, act_valid = 0;
  logic [BW-1:0] req_bank = 0, act_bank = 0;
  logic [RW-1:0] req_row = 0, act_row = 0;
  logic hint_valid;
  logic [BW-1:0] hint_bank;
  logic [SW-1:0] hint_subarray;
  logic [RW-1:0] hint_row;

  wir_detector #(.NUM_BANKS(NB), .ROW_W(RW), .SA_W(SW), .TRC(TR)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .act_valid(act_valid), .act_bank(act_bank),
    .act_row(act_row), .hint_valid(hint_valid), .hint_bank(hint_bank),
    .hint_subarray(hint_subarray), .hint_row(hint_row));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  int cur = 0;
  int act_at [NB];
  logic [RW-1:0] orow [NB];
  bit flag [NB];
  bit exp_v = 0;
  logic [BW-1:0] exp_b = 0;
  logic [RW-1:0] exp_r = 0;
  string exp_tag = "R1";
  bit mon_on = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Monitor: 1 ns after each rising edge, compare against the prediction.
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      check(hint_valid == exp_v, exp_tag, "hint_valid", hint_valid, exp_v);
      if (exp_v) begin
        check(hint_bank == exp_b, "R3", "hint_bank", hint_bank, exp_b);
        check(hint_row == exp_r, "R3", "hint_row", hint_row, exp_r);
        check(hint_subarray == exp_r[RW-1 -: SW], "R4", "hint_subarray",
              hint_subarray, exp_r[RW-1 -: SW]);
      end
    end
  end

  // One cycle of stimulus driven at the falling edge, with its prediction.
  task automatic cyc(input bit av, input int ab, input int ar,
                     input bit rv, input int rb, input int rr, input string tag);
    bit busy, fire;
    @(negedge clk);
    cur++;
    act_valid = av; act_bank = BW'(ab); act_row = RW'(ar);
    req_valid = rv; req_bank = BW'(rb); req_row = RW'(rr);
    busy = (cur - act_at[rb] >= 1) && (cur - act_at[rb] <= TR);
    fire = rv && busy && (RW'(rr) != orow[rb]) && !flag[rb];
    exp_v = fire; exp_b = BW'(rb); exp_r = orow[rb]; exp_tag = tag;
    if (fire) flag[rb] = 1;
    if (av) begin act_at[ab] = cur; orow[ab] = RW'(ar); flag[ab] = 0; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, "R9");
  endtask

  // Activate bank ab row ar, then a single request d cycles later.
  task automatic one_case(input int ab, input int ar, input int rb,
                          input int rr, input int d, input string tag);
    cyc(1, ab, ar, 0, 0, 0, tag);
    for (int i = 1; i < d; i++) cyc(0, 0, 0, 0, 0, 0, tag);
    cyc(0, 0, 0, 1, rb, rr, tag);
    idle(TR + 2);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin act_at[b] = -100; orow[b] = 0; flag[b] = 0; end
    repeat (3) @(negedge clk);
    check(hint_valid == 0, "R1", "hint_valid in reset", hint_valid, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check(hint_valid == 0, "R1", "hint_valid after reset", hint_valid, 0);
    mon_on = 1;

    // Window sweep, R2/R3: every offset, every bank, rows spread over subarrays.
    for (int b = 0; b < NB; b++)
      for (int d = 1; d <= TR + 2; d++)
        one_case(b, (b * 17 + 5) % 64, b, (b * 17 + 40) % 64, d, "R2");
    // R5: same row never hints.
    for (int b = 0; b < NB; b++)
      for (int d = 1; d <= TR; d++)
        one_case(b, 9 + b, b, 9 + b, d, "R5");
    // R6: request to an idle bank while another bank is busy.
    for (int b = 0; b < NB; b++)
      for (int d = 1; d <= TR; d++)
        one_case(b, 3, (b + 1) % NB, 50, d, "R6");
    // R9: conflicting fields with valid low.
    cyc(1, 2, 7, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 2, 60, "R9");
    cyc(0, 0, 0, 0, 2, 61, "R9");
    idle(TR + 2);
    // R7: several conflicts in one window give one hint.
    cyc(1, 1, 33, 0, 0, 0, "R7");
    for (int i = 0; i < TR; i++) cyc(0, 0, 0, 1, 1, 10 + i, "R7");
    idle(TR + 2);
    // R8: a fresh activate rearms the bank.
    cyc(1, 3, 20, 0, 0, 0, "R8");
    cyc(0, 0, 0, 1, 3, 21, "R8");
    cyc(1, 3, 44, 0, 0, 0, "R8");
    cyc(0, 0, 0, 1, 3, 45, "R8");
    cyc(0, 0, 0, 1, 3, 46, "R8");
    idle(TR + 2);
    // R10: overlapping windows in two banks.
    cyc(1, 0, 62, 0, 0, 0, "R10");
    cyc(1, 2, 15, 0, 0, 0, "R10");
    cyc(0, 0, 0, 1, 2, 1, "R10");
    cyc(0, 0, 0, 1, 0, 2, "R10");
    idle(TR + 2);
    mon_on = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    #10;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule